// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block paces auto-refresh for a DRAM controller. A free-running interval timer, reloaded from a programmable cycle count (the refresh period divided by the clock period), adds one refresh credit to an owed counter each time it expires. While credit is owed, the scheduler negotiates with the command arbiter through two request/grant pairs. One pair asks for a precharge of every bank, and the other asks for the refresh itself.

A refresh is only requested while the arbiter reports that every bank is closed. If a bank is open when credit is owed, the scheduler first asks for a precharge-all. It then waits for the all-closed indication. Because a refresh closes banks internally, no further precharge is needed afterwards. Refreshes may be deferred, and the owed count accumulates up to a hard ceiling of eight. At the ceiling an urgent flag tells the arbiter to stop opening rows until a refresh is granted.

Top module: `rfsh_sched`

## Requirements
- R1: With `interval_i` = N (N >= 1), the owed count rises by one on every Nth rising clock edge after reset release. The first rise happens at edge N.
- R2: The owed count never exceeds 8; an interval expiring at 8 is dropped. `urgent_o` is 1 exactly when the count is 8.
- R3: A refresh handshake (`rfsh_req_o` and `rfsh_gnt_i` both 1 at an edge) lowers the count by one. A handshake at the same edge as an interval expiry leaves the count unchanged. `rfsh_gnt_i` has no effect while no request is raised, and the count never goes below zero.
- R4: With credit owed and `banks_idle_i` = 1 while idle, `rfsh_req_o` rises one cycle after the credit appears. It drops for one cycle after each handshake, and it is never 1 with zero credit.
- R5: With credit owed and `banks_idle_i` = 0, `pchg_req_o` rises one cycle after the credit appears. It stays 1 until `pchg_gnt_i`, and no refresh is requested meanwhile.
- R6: After the precharge grant, both requests stay 0 until `banks_idle_i` is 1. `rfsh_req_o` then rises at the following edge.
- R7: `rfsh_req_o` is 0 in any cycle where `banks_idle_i` is 0. If the banks reopen during a refresh request, a new precharge request follows at the next edge.
- R8: During and right after reset, the count is 0 and all of `pchg_req_o`, `rfsh_req_o` and `urgent_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| interval_i | input | INTERVAL_W | Clock cycles per refresh interval (>= 1) |
| banks_idle_i | input | 1 | All banks precharged |
| pchg_req_o | output | 1 | Precharge-all request |
| pchg_gnt_i | input | 1 | Precharge-all grant |
| rfsh_req_o | output | 1 | Auto-refresh request |
| rfsh_gnt_i | input | 1 | Auto-refresh grant |
| urgent_o | output | 1 | Owed count at ceiling; block activates |
| owed_o | output | OWED_W | Refreshes currently owed |

## Verification
An off-by-one in the interval timer shows up on `owed_o` one cycle early or late at the first expiry. The error then grows by one cycle at every later interval. A lost or duplicated credit update shows immediately on `owed_o`: at the ceiling, at zero, or when an expiry and a grant coincide. A wrong sequencer state shows within a cycle as a request raised on the wrong pair or held through an unexpected handshake. The scoreboard catches such a handshake as a mismatched or unexpected event.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PCHG,
    ST_WAIT,
    ST_RFSH
  } rfsh_state_e;
endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int INTERVAL_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [INTERVAL_W-1:0] interval_i,
  output logic                  tick_o
);
  logic [INTERVAL_W-1:0] cnt_q;
  logic [INTERVAL_W-1:0] last;

  assign last   = interval_i - 1'b1;
  assign tick_o = (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R1: counter restarts after each expiry
  a_r1_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/rfsh_credit.sv
module rfsh_credit #(
  parameter int MAX_OWED = 8,
  localparam int OWED_W  = $clog2(MAX_OWED + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              issue_i,
  output logic [OWED_W-1:0] owed_o,
  output logic              urgent_o
);
  localparam logic [OWED_W-1:0] CAP = OWED_W'(MAX_OWED);

  logic [OWED_W-1:0] owed_q;
  logic inc, dec;

  assign inc = tick_i && (owed_q != CAP);
  assign dec = issue_i && (owed_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         owed_q <= '0;
    else if (inc && !dec) owed_q <= owed_q + 1'b1;
    else if (dec && !inc) owed_q <= owed_q - 1'b1;
  end

  assign owed_o   = owed_q;
  assign urgent_o = (owed_q == CAP);

  a_r2_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owed_q <= CAP);
  a_r3_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && !tick_i && owed_q != '0) |=> (owed_q == $past(owed_q) - 1'b1));
  a_r1_increment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !issue_i && owed_q != CAP) |=> (owed_q == $past(owed_q) + 1'b1));
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
  import rfsh_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic credit_i,
  input  logic banks_idle_i,
  input  logic pchg_gnt_i,
  input  logic rfsh_gnt_i,
  output logic pchg_req_o,
  output logic rfsh_req_o
);
  rfsh_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (credit_i) state_d = banks_idle_i ? ST_RFSH : ST_PCHG;
      ST_PCHG: if (pchg_gnt_i) state_d = ST_WAIT;
      ST_WAIT: if (banks_idle_i) state_d = ST_RFSH;
      ST_RFSH: begin
        if (!banks_idle_i)   state_d = ST_PCHG;  // a row was reopened
        else if (rfsh_gnt_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign pchg_req_o = (state_q == ST_PCHG);
  assign rfsh_req_o = (state_q == ST_RFSH) && banks_idle_i;

  a_r4_needs_credit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfsh_req_o |-> credit_i);
  a_r5_pchg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pchg_req_o && !pchg_gnt_i) |=> pchg_req_o);
  a_r5_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pchg_req_o && rfsh_req_o));
  a_r7_reopen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RFSH && !banks_idle_i) |=> pchg_req_o);
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched #(
  parameter int INTERVAL_W = 16,
  parameter int MAX_OWED   = 8,
  localparam int OWED_W    = $clog2(MAX_OWED + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [INTERVAL_W-1:0] interval_i,
  input  logic                  banks_idle_i,
  output logic                  pchg_req_o,
  input  logic                  pchg_gnt_i,
  output logic                  rfsh_req_o,
  input  logic                  rfsh_gnt_i,
  output logic                  urgent_o,
  output logic [OWED_W-1:0]     owed_o
);
  logic tick, issue;

  rfsh_timer #(.INTERVAL_W(INTERVAL_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .interval_i(interval_i),
    .tick_o    (tick)
  );

  assign issue = rfsh_req_o && rfsh_gnt_i;

  rfsh_credit #(.MAX_OWED(MAX_OWED)) u_credit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .issue_i (issue),
    .owed_o  (owed_o),
    .urgent_o(urgent_o)
  );

  rfsh_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .credit_i    (owed_o != '0),
    .banks_idle_i(banks_idle_i),
    .pchg_gnt_i  (pchg_gnt_i),
    .rfsh_gnt_i  (rfsh_gnt_i),
    .pchg_req_o  (pchg_req_o),
    .rfsh_req_o  (rfsh_req_o)
  );

  // R7: refresh never requested with a bank open
  a_r7_idle_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfsh_req_o |-> banks_idle_i);
endmodule

// File: tb/rfsh_sched_tb_top.sv
module rfsh_sched_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] interval = 16'd20;
  logic        banks_idle = 1'b1;
  logic        pchg_gnt = 1'b0;
  logic        rfsh_gnt = 1'b0;
  logic        pchg_req, rfsh_req, urgent;
  logic [3:0]  owed;

  int errors = 0;
  int checks = 0;
  int t = 0;
  byte exp_q[$];  // expected handshake kinds: "P" or "R"

  always #2.5 clk = ~clk;

  rfsh_sched dut_i (
    .clk_i(clk), .rst_ni(rst_n), .interval_i(interval),
    .banks_idle_i(banks_idle), .pchg_req_o(pchg_req), .pchg_gnt_i(pchg_gnt),
    .rfsh_req_o(rfsh_req), .rfsh_gnt_i(rfsh_gnt), .urgent_o(urgent), .owed_o(owed)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s t=%0d actual=%0d expected=%0d", req, t, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; t++;
    end
  endtask

  task automatic go_to(input int target);
    step(target - t);
  endtask

  task automatic do_reset(input int n);
    rst_n = 1'b0; interval = 16'(n);
    rfsh_gnt = 0; pchg_gnt = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 owed in reset", owed, 0);
    chk("R8 reqs in reset", {pchg_req, rfsh_req, urgent}, 0);
    rst_n = 1'b1; t = 0;
  endtask

  // monitor: compare handshakes against expected queue
  always @(negedge clk) begin
    if (rst_n && (pchg_req && pchg_gnt || rfsh_req && rfsh_gnt)) begin
      byte kind;
      kind = (pchg_req && pchg_gnt) ? "P" : "R";
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3 unexpected handshake actual=%c expected=none", kind);
      end else begin
        byte e;
        e = exp_q.pop_front();
        if (e != kind) begin
          errors++;
          $display("FAIL R5 handshake actual=%c expected=%c", kind, e);
        end
      end
    end
  end

  initial begin
    fork
      begin
        #2ms;
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none

    // Scenario A: banks idle, interval 20
    banks_idle = 1;
    do_reset(20);
    chk("R8 owed after release", owed, 0);
    go_to(19);  chk("R1 before first expiry", owed, 0);
    go_to(20);  chk("R1 first expiry", owed, 1);
    chk("R4 not yet requested", rfsh_req, 0);
    go_to(21);  chk("R4 request one cycle later", rfsh_req, 1);
    go_to(140); chk("R1 seventh credit", owed, 7);
    chk("R2 not urgent at 7", urgent, 0);
    go_to(160); chk("R2 eighth credit", owed, 8);
    chk("R2 urgent at 8", urgent, 1);
    go_to(200); chk("R2 saturates", owed, 8);
    go_to(202); exp_q.push_back("R"); rfsh_gnt = 1;
    go_to(203); rfsh_gnt = 0;
    chk("R3 decrement", owed, 7);
    chk("R4 drop after handshake", rfsh_req, 0);
    go_to(204); chk("R4 re-request", rfsh_req, 1);
    go_to(219); exp_q.push_back("R"); rfsh_gnt = 1;
    go_to(220); rfsh_gnt = 0;
    chk("R3 expiry and grant together", owed, 7);

    // Scenario C: drain to zero, stray grants ignored
    do_reset(30);
    go_to(31); chk("R4 request", rfsh_req, 1);
    exp_q.push_back("R"); rfsh_gnt = 1;
    go_to(32); chk("R3 down to zero", owed, 0);
    go_to(34); chk("R3 stray grant ignored", owed, 0);
    chk("R4 no request at zero", rfsh_req, 0);
    rfsh_gnt = 0;

    // Scenario D: bank open path
    banks_idle = 0;
    do_reset(30);
    go_to(30); chk("R1 credit", owed, 1);
    go_to(31); chk("R5 precharge request", pchg_req, 1);
    go_to(34); chk("R5 held without grant", pchg_req, 1);
    chk("R5 no refresh while open", rfsh_req, 0);
    exp_q.push_back("P"); pchg_gnt = 1;
    go_to(35); pchg_gnt = 0;
    chk("R6 waiting, no precharge req", pchg_req, 0);
    chk("R6 waiting, no refresh req", rfsh_req, 0);
    go_to(37); chk("R6 still waiting", rfsh_req, 0);
    banks_idle = 1;
    go_to(38); chk("R6 refresh after idle", rfsh_req, 1);
    banks_idle = 0; #1;
    chk("R7 drop with bank open", rfsh_req, 0);
    go_to(39); chk("R7 precharge again", pchg_req, 1);
    banks_idle = 1; exp_q.push_back("P"); pchg_gnt = 1;
    go_to(40); pchg_gnt = 0;
    go_to(41); chk("R6 refresh request", rfsh_req, 1);
    exp_q.push_back("R"); rfsh_gnt = 1;
    go_to(42); rfsh_gnt = 0;
    chk("R3 refresh done", owed, 0);
    step(2);
    chk("R3 all handshakes seen", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule